// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block decides when a processor core stops normal execution and hands control to a debugger, halts for good in checkstop, or takes an ordinary machine-check interrupt. Incoming event pulses (trace, several kinds of breakpoint, development-port requests and machine check) are qualified and recorded as sticky bits in a 32-bit cause register. A 32-bit enable register says which causes may stop the core. When any recorded cause has its enable bit set and the global debug enable is on, the controller commits to debug entry. It then waits for the pipeline to drain before it asserts debug mode, freeze and the debug status code.

Machine checks are resolved in one of three ways: checkstop, debug mode, or a one-cycle interrupt request. The choice depends on the machine-check-enable flag, the global debug enable and two bits of the enable register. The development port reads the cause register to learn why the core stopped. That read also clears the register. A single-cycle exit pulse from the port ends debug mode. Only reset leaves checkstop.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: Each accepted event sets its own cause bit: development-port nonmaskable request bit 0, external maskable breakpoint bit 1, load/store maskable breakpoint bit 2, instruction maskable breakpoint bit 3, nonmaskable breakpoint bit 4, trace bit 16. Bits are sticky and OR-accumulate until a read, and the register reads 0 after reset.
- R2: The three maskable breakpoints set no cause bit while `recov_i` is 0. The nonmaskable breakpoint and the nonmaskable development-port request are always recorded.
- R3: Debug entry is committed only when `dbg_en_i` is 1 and the bitwise AND of the cause and enable registers is nonzero. With `pipe_empty_i` high, `dbg_mode_o` rises on the second rising edge after the event cycle.
- R4: Once entry is committed, `dbg_mode_o` stays low while `pipe_empty_i` is 0. It rises on the first edge at which `pipe_empty_i` is 1.
- R5: In debug mode, `status_o` is 2'b11 and `freeze_o` is 1. Outside debug mode, `status_o` is 2'b00 and `freeze_o` is 0.
- R6: `cause_o` always shows the cause register. A cycle with `cause_rd_i` high clears every old bit at the next edge, and a bit set by an event in that same cycle survives.
- R7: A machine check with `mce_i` = 0 sets cause bit 29 (32'h2000_0000). It enters debug mode when `dbg_en_i` and enable bit 29 are both 1. Otherwise it enters checkstop at the next edge.
- R8: A machine check with `mce_i` = 1 sets cause bit 28 (32'h1000_0000). It enters debug mode when `dbg_en_i` and enable bit 28 are both 1. Otherwise `mchk_irq_o` is high for exactly one cycle, starting at the next edge.
- R9: Checkstop is terminal. `chkstop_o` stays 1, and no exit pulse, event or interrupt request changes it. Only reset clears it. `dbg_mode_o` is 0 in checkstop.
- R10: An `exit_i` pulse while in debug mode drops `dbg_mode_o`, `freeze_o` and `status_o` at the next edge.
- R11: The enable register loads `en_wdata_i` on a cycle with `en_we_i` high and resets to all zeros.
- R12: After reset, `dbg_mode_o`, `chkstop_o`, `freeze_o`, `mchk_irq_o` and `status_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_en_i | input | 1 | Global debug-mode enable |
| recov_i | input | 1 | Recoverable-interrupt flag; gates maskable breakpoints |
| mce_i | input | 1 | Machine-check interrupt enable |
| ev_trace_i | input | 1 | Trace event pulse |
| ev_ibrk_i | input | 1 | Maskable instruction breakpoint pulse |
| ev_lsbrk_i | input | 1 | Maskable load/store breakpoint pulse |
| ev_xbrk_i | input | 1 | Maskable breakpoint from external modules via the port |
| ev_nmbrk_i | input | 1 | Nonmaskable breakpoint pulse |
| ev_dpnmi_i | input | 1 | Development-port nonmaskable request |
| ev_mchk_i | input | 1 | Machine-check event pulse |
| pipe_empty_i | input | 1 | Pipeline drained |
| exit_i | input | 1 | Single-cycle debug-exit pulse |
| cause_rd_i | input | 1 | Cause read strobe; clears the register |
| cause_o | output | 32 | Cause register contents |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 32 | Enable register write data |
| dbg_mode_o | output | 1 | Core is in debug mode |
| chkstop_o | output | 1 | Core is in checkstop |
| freeze_o | output | 1 | Freeze indication to peripherals |
| status_o | output | 2 | Status code, 2'b11 in debug mode |
| mchk_irq_o | output | 1 | One-cycle take-machine-check-interrupt pulse |

## Verification
The bench covers all four machine-check routings. A design that mixed them up would raise checkstop where an interrupt is due, or store cause 32'h1000_0000 where 32'h2000_0000 belongs. It fires maskable breakpoints with the recoverable flag low, and a design that ignored the flag would record them and stop the core. It holds the pipeline busy after an enabled event, and a design that skipped the drain wait would raise debug mode early. It also fires an event in the same cycle as a cause read, and a design that gave the clear priority would lose the new bit. Further tests check that checkstop survives exit pulses and new events, and that an exit really drops freeze and the status code.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;

   localparam int unsigned CAUSE_W_DEF = 32;

   // cause / enable bit positions
   localparam int unsigned CB_DPNMI = 0;
   localparam int unsigned CB_XBRK  = 1;
   localparam int unsigned CB_LSBRK = 2;
   localparam int unsigned CB_IBRK  = 3;
   localparam int unsigned CB_NMBRK = 4;
   localparam int unsigned CB_TRACE = 16;
   localparam int unsigned CB_MCI   = 28;
   localparam int unsigned CB_CKSTP = 29;

   localparam int unsigned CB_TOP   = CB_CKSTP;

   localparam logic [1:0] STAT_NORMAL = 2'b00;
   localparam logic [1:0] STAT_DEBUG  = 2'b11;

   typedef enum logic [1:0] {
      ST_RUN     = 2'd0,
      ST_DRAIN   = 2'd1,
      ST_DEBUG   = 2'd2,
      ST_CHKSTOP = 2'd3
   } dbg_state_e;

endpackage

// File: rtl/dbg_event_qual.sv
module dbg_event_qual
   import dbg_entry_pkg::*;
#(
   parameter int unsigned CAUSE_W = CAUSE_W_DEF
) (
   input  logic               recov_i,
   input  logic               mce_i,
   input  logic               dbg_en_i,
   input  logic [CAUSE_W-1:0] en_q_i,
   input  logic               ev_trace_i,
   input  logic               ev_ibrk_i,
   input  logic               ev_lsbrk_i,
   input  logic               ev_xbrk_i,
   input  logic               ev_nmbrk_i,
   input  logic               ev_dpnmi_i,
   input  logic               ev_mchk_i,
   output logic [CAUSE_W-1:0] set_o,
   output logic               ckstop_take_o,
   output logic               irq_take_o
);

   logic mchk_to_dbg_ck;
   logic mchk_to_dbg_mi;

   always_comb begin
      set_o           = '0;
      set_o[CB_TRACE] = ev_trace_i;
      set_o[CB_IBRK]  = ev_ibrk_i  & recov_i;
      set_o[CB_LSBRK] = ev_lsbrk_i & recov_i;
      set_o[CB_XBRK]  = ev_xbrk_i  & recov_i;
      set_o[CB_NMBRK] = ev_nmbrk_i;
      set_o[CB_DPNMI] = ev_dpnmi_i;
      set_o[CB_MCI]   = ev_mchk_i & mce_i;
      set_o[CB_CKSTP] = ev_mchk_i & ~mce_i;
   end

   assign mchk_to_dbg_ck = dbg_en_i & en_q_i[CB_CKSTP];
   assign mchk_to_dbg_mi = dbg_en_i & en_q_i[CB_MCI];

   assign ckstop_take_o = ev_mchk_i & ~mce_i & ~mchk_to_dbg_ck;
   assign irq_take_o    = ev_mchk_i &  mce_i & ~mchk_to_dbg_mi;

endmodule

// File: rtl/dbg_cause_reg.sv
module dbg_cause_reg
   import dbg_entry_pkg::*;
#(
   parameter int unsigned CAUSE_W = CAUSE_W_DEF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CAUSE_W-1:0] set_i,
   input  logic               rd_i,
   output logic [CAUSE_W-1:0] q_o
);

   for (genvar b = 0; b < CAUSE_W; b++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk) begin
         if (!rst_n) bit_q <= 1'b0;
         else        bit_q <= (bit_q & ~rd_i) | set_i[b];
      end
      assign q_o[b] = bit_q;
   end

endmodule

// File: rtl/dbg_enable_reg.sv
module dbg_enable_reg
   import dbg_entry_pkg::*;
#(
   parameter int unsigned CAUSE_W = CAUSE_W_DEF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we_i,
   input  logic [CAUSE_W-1:0] wdata_i,
   output logic [CAUSE_W-1:0] q_o
);

   always_ff @(posedge clk) begin
      if (!rst_n)    q_o <= '0;
      else if (we_i) q_o <= wdata_i;
   end

endmodule

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm
   import dbg_entry_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pend_i,
   input  logic pipe_empty_i,
   input  logic exit_i,
   input  logic ckstop_take_i,
   input  logic irq_take_i,
   output logic in_debug_o,
   output logic in_ckstop_o,
   output logic irq_o
);

   dbg_state_e st_q, st_d;
   logic       irq_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_RUN:     if (pend_i) st_d = pipe_empty_i ? ST_DEBUG : ST_DRAIN;
         ST_DRAIN:   if (pipe_empty_i) st_d = ST_DEBUG;
         ST_DEBUG:   if (exit_i) st_d = ST_RUN;
         ST_CHKSTOP: st_d = ST_CHKSTOP;
         default:    st_d = ST_RUN;
      endcase
      if (ckstop_take_i) st_d = ST_CHKSTOP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_RUN;
         irq_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         irq_q <= irq_take_i & (st_q != ST_CHKSTOP);
      end
   end

   assign in_debug_o  = (st_q == ST_DEBUG);
   assign in_ckstop_o = (st_q == ST_CHKSTOP);
   assign irq_o       = irq_q;

endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
   import dbg_entry_pkg::*;
#(
   parameter int unsigned CAUSE_W = CAUSE_W_DEF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dbg_en_i,
   input  logic               recov_i,
   input  logic               mce_i,
   input  logic               ev_trace_i,
   input  logic               ev_ibrk_i,
   input  logic               ev_lsbrk_i,
   input  logic               ev_xbrk_i,
   input  logic               ev_nmbrk_i,
   input  logic               ev_dpnmi_i,
   input  logic               ev_mchk_i,
   input  logic               pipe_empty_i,
   input  logic               exit_i,
   input  logic               cause_rd_i,
   output logic [CAUSE_W-1:0] cause_o,
   input  logic               en_we_i,
   input  logic [CAUSE_W-1:0] en_wdata_i,
   output logic               dbg_mode_o,
   output logic               chkstop_o,
   output logic               freeze_o,
   output logic [1:0]         status_o,
   output logic               mchk_irq_o
);

   if (CAUSE_W <= CB_TOP) begin : g_width_check
      $error("CAUSE_W must exceed the highest cause bit position");
   end

   logic [CAUSE_W-1:0] en_q;
   logic [CAUSE_W-1:0] cause_q;
   logic [CAUSE_W-1:0] set_vec;
   logic               ckstop_take;
   logic               irq_take;
   logic               pend;
   logic               in_debug;

   dbg_enable_reg #(.CAUSE_W(CAUSE_W)) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (en_we_i),
      .wdata_i (en_wdata_i),
      .q_o     (en_q)
   );

   dbg_event_qual #(.CAUSE_W(CAUSE_W)) u_qual (
      .recov_i       (recov_i),
      .mce_i         (mce_i),
      .dbg_en_i      (dbg_en_i),
      .en_q_i        (en_q),
      .ev_trace_i    (ev_trace_i),
      .ev_ibrk_i     (ev_ibrk_i),
      .ev_lsbrk_i    (ev_lsbrk_i),
      .ev_xbrk_i     (ev_xbrk_i),
      .ev_nmbrk_i    (ev_nmbrk_i),
      .ev_dpnmi_i    (ev_dpnmi_i),
      .ev_mchk_i     (ev_mchk_i),
      .set_o         (set_vec),
      .ckstop_take_o (ckstop_take),
      .irq_take_o    (irq_take)
   );

   dbg_cause_reg #(.CAUSE_W(CAUSE_W)) u_cause (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec),
      .rd_i  (cause_rd_i),
      .q_o   (cause_q)
   );

   assign pend = dbg_en_i & (|(cause_q & en_q));

   dbg_mode_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .pend_i        (pend),
      .pipe_empty_i  (pipe_empty_i),
      .exit_i        (exit_i),
      .ckstop_take_i (ckstop_take),
      .irq_take_i    (irq_take),
      .in_debug_o    (in_debug),
      .in_ckstop_o   (chkstop_o),
      .irq_o         (mchk_irq_o)
   );

   assign cause_o    = cause_q;
   assign dbg_mode_o = in_debug;
   assign freeze_o   = in_debug;
   assign status_o   = in_debug ? STAT_DEBUG : STAT_NORMAL;

endmodule

// File: rtl/dbg_entry_chk.sv
module dbg_entry_chk #(
   parameter int unsigned CAUSE_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ev_trace_i,
   input logic               ev_ibrk_i,
   input logic               ev_lsbrk_i,
   input logic               ev_xbrk_i,
   input logic               ev_nmbrk_i,
   input logic               ev_dpnmi_i,
   input logic               ev_mchk_i,
   input logic               pipe_empty_i,
   input logic               exit_i,
   input logic               cause_rd_i,
   input logic [CAUSE_W-1:0] cause_o,
   input logic               dbg_mode_o,
   input logic               chkstop_o,
   input logic               freeze_o,
   input logic [1:0]         status_o,
   input logic               mchk_irq_o
);

   logic any_ev;
   assign any_ev = ev_trace_i | ev_ibrk_i | ev_lsbrk_i | ev_xbrk_i |
                   ev_nmbrk_i | ev_dpnmi_i | ev_mchk_i;

   assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !cause_rd_i |=> ((cause_o & $past(cause_o)) == $past(cause_o)));

   assert_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dbg_mode_o) |-> $past(pipe_empty_i));

   assert_dbg_ind_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_mode_o |-> (status_o == 2'b11 && freeze_o));

   assert_norm_ind_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_mode_o |-> (status_o == 2'b00 && !freeze_o));

   assert_rd_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_rd_i && !any_ev) |=> (cause_o == '0));

   assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mchk_irq_o |=> !mchk_irq_o);

   assert_ckstop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      chkstop_o |=> chkstop_o);

   assert_ckstop_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      chkstop_o |-> !dbg_mode_o);

   assert_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_mode_o && exit_i) |=> !dbg_mode_o);

endmodule

bind dbg_entry_ctrl dbg_entry_chk #(.CAUSE_W(CAUSE_W)) u_chk (.*);

// File: tb/test_dbg_entry_ctrl.sv
module test_dbg_entry_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbg_en = 1'b0, recov = 1'b0, mce = 1'b0;
   logic [6:0]  ev = '0;   // {mchk, dpnmi, nmbrk, xbrk, lsbrk, ibrk, trace}
   logic        pipe_empty = 1'b1, exit_p = 1'b0, cause_rd = 1'b0;
   logic        en_we = 1'b0;
   logic [31:0] en_wdata = '0;
   logic [31:0] cause;
   logic        dbg_mode, chkstop, freeze, mchk_irq;
   logic [1:0]  status;

   int n_checks = 0;
   int n_fail   = 0;
   int irq_cnt  = 0;
   bit done     = 0;

   always #10 clk = ~clk;  // 50 MHz

   dbg_entry_ctrl i_dbg_entry_ctrl (
      .clk(clk), .rst_n(rst_n), .dbg_en_i(dbg_en), .recov_i(recov), .mce_i(mce),
      .ev_trace_i(ev[0]), .ev_ibrk_i(ev[1]), .ev_lsbrk_i(ev[2]), .ev_xbrk_i(ev[3]),
      .ev_nmbrk_i(ev[4]), .ev_dpnmi_i(ev[5]), .ev_mchk_i(ev[6]),
      .pipe_empty_i(pipe_empty), .exit_i(exit_p), .cause_rd_i(cause_rd),
      .cause_o(cause), .en_we_i(en_we), .en_wdata_i(en_wdata),
      .dbg_mode_o(dbg_mode), .chkstop_o(chkstop), .freeze_o(freeze),
      .status_o(status), .mchk_irq_o(mchk_irq)
   );

   always @(negedge clk) if (mchk_irq) irq_cnt++;

   typedef struct packed {
      logic        dbg_en, ri, me;
      logic [31:0] en;
      logic [6:0]  ev;
      logic        x_dbg, x_ck, x_irq;
      logic [31:0] x_cause;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{1'b1,1'b1,1'b0, 32'h0001_0000, 7'h01, 1'b1,1'b0,1'b0, 32'h0001_0000},
      '{1'b1,1'b0,1'b0, 32'h0000_0008, 7'h02, 1'b0,1'b0,1'b0, 32'h0000_0000},
      '{1'b1,1'b1,1'b0, 32'h0000_0008, 7'h02, 1'b1,1'b0,1'b0, 32'h0000_0008},
      '{1'b1,1'b0,1'b0, 32'h0000_0010, 7'h10, 1'b1,1'b0,1'b0, 32'h0000_0010},
      '{1'b1,1'b0,1'b0, 32'h0000_0001, 7'h20, 1'b1,1'b0,1'b0, 32'h0000_0001},
      '{1'b0,1'b1,1'b0, 32'hFFFF_FFFF, 7'h01, 1'b0,1'b0,1'b0, 32'h0001_0000},
      '{1'b1,1'b1,1'b0, 32'h0000_0004, 7'h08, 1'b0,1'b0,1'b0, 32'h0000_0002},
      '{1'b0,1'b1,1'b0, 32'h0000_0000, 7'h40, 1'b0,1'b1,1'b0, 32'h2000_0000},
      '{1'b0,1'b1,1'b1, 32'h1000_0000, 7'h40, 1'b0,1'b0,1'b1, 32'h1000_0000},
      '{1'b1,1'b1,1'b0, 32'h0000_0000, 7'h40, 1'b0,1'b1,1'b0, 32'h2000_0000},
      '{1'b1,1'b1,1'b0, 32'h2000_0000, 7'h40, 1'b1,1'b0,1'b0, 32'h2000_0000},
      '{1'b1,1'b1,1'b1, 32'h1000_0000, 7'h40, 1'b1,1'b0,1'b0, 32'h1000_0000},
      '{1'b1,1'b1,1'b1, 32'h0000_0000, 7'h40, 1'b0,1'b0,1'b1, 32'h1000_0000},
      '{1'b1,1'b0,1'b0, 32'h0001_0000, 7'h0D, 1'b1,1'b0,1'b0, 32'h0001_0000},
      '{1'b1,1'b0,1'b0, 32'h0000_0004, 7'h04, 1'b0,1'b0,1'b0, 32'h0000_0000}
   };

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; ev = '0; exit_p = 1'b0; cause_rd = 1'b0; en_we = 1'b0;
      pipe_empty = 1'b1; dbg_en = 1'b0; recov = 1'b0; mce = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic write_en(logic [31:0] v);
      en_we = 1'b1; en_wdata = v;
      step(1);
      en_we = 1'b0;
   endtask

   task automatic pulse_ev(logic [6:0] e);
      ev = e;
      step(1);
      ev = '0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         summary();
         $finish;
      end
   end

   initial begin
      // R12 reset state
      do_reset();
      check("R12", "dbg_mode", {31'b0, dbg_mode}, 32'h0);
      check("R12", "chkstop",  {31'b0, chkstop},  32'h0);
      check("R12", "freeze",   {31'b0, freeze},   32'h0);
      check("R12", "status",   {30'b0, status},   32'h0);
      check("R12", "mchk_irq", {31'b0, mchk_irq}, 32'h0);
      check("R1",  "cause after reset", cause, 32'h0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         string rq;
         vec_t v = VECS[i];
         rq = v.ev[6] ? (v.me ? "R8" : "R7") : (v.ri ? "R3" : "R2");
         do_reset();
         dbg_en = v.dbg_en; recov = v.ri; mce = v.me;
         write_en(v.en);
         irq_cnt = 0;
         pulse_ev(v.ev);
         step(3);
         check(rq, $sformatf("vec%0d dbg_mode", i), {31'b0, dbg_mode}, {31'b0, v.x_dbg});
         check(rq, $sformatf("vec%0d chkstop", i),  {31'b0, chkstop},  {31'b0, v.x_ck});
         check(rq, $sformatf("vec%0d irq count", i), irq_cnt, {31'b0, v.x_irq});
         check("R5", $sformatf("vec%0d status", i), {30'b0, status}, v.x_dbg ? 32'h3 : 32'h0);
         check("R5", $sformatf("vec%0d freeze", i), {31'b0, freeze}, {31'b0, v.x_dbg});
         check("R1", $sformatf("vec%0d cause", i), cause, v.x_cause);
         cause_rd = 1'b1;
         step(1);
         cause_rd = 1'b0;
         check("R6", $sformatf("vec%0d cause after read", i), cause, 32'h0);
      end

      // R4 pipeline drain, R5 indication, R10 exit
      do_reset();
      dbg_en = 1'b1; recov = 1'b1;
      write_en(32'h0001_0000);
      pipe_empty = 1'b0;
      pulse_ev(7'h01);
      step(4);
      check("R4", "dbg_mode while pipeline busy", {31'b0, dbg_mode}, 32'h0);
      pipe_empty = 1'b1;
      step(1);
      check("R4", "dbg_mode after drain", {31'b0, dbg_mode}, 32'h1);
      cause_rd = 1'b1; step(1); cause_rd = 1'b0;
      check("R5", "status in debug", {30'b0, status}, 32'h3);
      check("R5", "freeze in debug", {31'b0, freeze}, 32'h1);
      exit_p = 1'b1; step(1); exit_p = 1'b0;
      check("R10", "dbg_mode after exit", {31'b0, dbg_mode}, 32'h0);
      check("R10", "status after exit",   {30'b0, status},   32'h0);
      check("R10", "freeze after exit",   {31'b0, freeze},   32'h0);
      step(2);
      check("R10", "no re-entry with cleared cause", {31'b0, dbg_mode}, 32'h0);

      // R6 read collision, R1 accumulation
      do_reset();
      recov = 1'b1;
      pulse_ev(7'h01);
      check("R1", "trace bit", cause, 32'h0001_0000);
      cause_rd = 1'b1; ev = 7'h02;
      step(1);
      cause_rd = 1'b0; ev = '0;
      check("R6", "event during read survives", cause, 32'h0000_0008);
      pulse_ev(7'h10);
      check("R1", "accumulate nonmaskable bp", cause, 32'h0000_0018);
      pulse_ev(7'h08);
      check("R1", "accumulate external bp", cause, 32'h0000_001A);

      // R11 enable register resets to zero
      do_reset();
      dbg_en = 1'b1; recov = 1'b1;
      pulse_ev(7'h01);
      step(3);
      check("R11", "no entry with reset enables", {31'b0, dbg_mode}, 32'h0);
      check("R11", "cause still recorded", cause, 32'h0001_0000);
      write_en(32'h0001_0000);
      step(2);
      check("R11", "entry after enable write", {31'b0, dbg_mode}, 32'h1);

      // R9 checkstop is terminal
      do_reset();
      pulse_ev(7'h40);
      check("R7", "checkstop one edge after mc", {31'b0, chkstop}, 32'h1);
      exit_p = 1'b1; step(1); exit_p = 1'b0;
      dbg_en = 1'b1; recov = 1'b1;
      write_en(32'hFFFF_FFFF);
      mce = 1'b1; irq_cnt = 0;
      pulse_ev(7'h41);
      step(3);
      check("R9", "checkstop held", {31'b0, chkstop}, 32'h1);
      check("R9", "no debug in checkstop", {31'b0, dbg_mode}, 32'h0);
      check("R9", "no irq in checkstop", irq_cnt, 32'h0);
      do_reset();
      check("R12", "reset leaves checkstop", {31'b0, chkstop}, 32'h0);

      done = 1;
      summary();
      $finish;
   end

endmodule